// File: doc/BRIEF.md
# Key-Gated Indexed Configuration Port

This block is the configuration front end of a multi-function peripheral controller. The host reaches it over a byte-wide bus with a single address bit. Offset 0 is the index port and offset 1 is the data port. The register file stays locked until the host writes an unlock key byte to the index port. After that, the host writes a register number to the index port and then reads or writes that register through the data port. A second key byte locks the port again.

Indices below 0x30 reach a small global register set. This set includes a device selector, a fixed identifier, a revision byte and three writable control bytes. Indices 0x30 and above reach the register bank of one logical device, and the device selector chooses which bank that is. Each bank holds an activate flag, a 16-bit base address, two interrupt-select fields and a mode byte. All of these are driven continuously on the block's outputs, so the functions of the controller can pick up their settings.

Top module: `keyed_cfg_port`

## Requirements
- R1: Reset locks the port, clears the device selector, the index and all global control bytes, and drives every enable, base, interrupt and mode output and `bus_rdata` to zero.
- R2: While locked, writing 0x55 to the index port (offset 0) unlocks. While unlocked, writing 0xAA to the index port locks. Lock and unlock leave the current index unchanged. While locked, any other index write is ignored.
- R3: While locked, data-port writes change no register or output, and reads of either port return 0xFF.
- R4: Index 0x20 reads 0x4D and index 0x21 reads the revision byte (0x01 by default). Writes to both are discarded.
- R5: Index 0x07 is a read/write device selector. Index values 0x30 and above reach the bank whose device number matches it: 0x00 (slot 0), 0x04 (slot 1), 0x05 (slot 2) or 0x07 (slot 3).
- R6: Bank registers: 0x30 keeps only bit 0 and reads 0 in bits 7..1. 0x60 is base bits 15..8 and 0x61 is base bits 7..0. 0x70 and 0x72 keep the low 4 bits and read 0 above them. 0xF0 keeps all 8 bits.
- R7: While the selector holds a number that matches no bank, bank indices read 0x00 and writes to them are discarded.
- R8: Unimplemented global or bank indices read 0x00, and writes to them are discarded.
- R9: Each slot's enable, base, interrupt and mode outputs follow its bank registers from the edge that samples the write. Slot i occupies bit i of `dev_en` and field i of each packed output.
- R10: The index persists across data accesses, so repeated data accesses target the same register. While unlocked, a read of the index port returns the current index.
- R11: `bus_rdata` is registered. It is updated by the edge that samples `bus_rd` high and holds its value while `bus_rd` is low.
- R12: Global indices 0x22, 0x23 and 0x24 are 8-bit read/write registers while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_en | output | NUM_DEV | Per-slot enable (activate bit 0) |
| dev_base | output | 16*NUM_DEV | Per-slot base address |
| dev_irq_a | output | IRQ_W*NUM_DEV | Per-slot primary interrupt select |
| dev_irq_b | output | IRQ_W*NUM_DEV | Per-slot secondary interrupt select |
| dev_mode | output | 8*NUM_DEV | Per-slot mode byte |

## Verification
Every write, whether it is a key, an index or a data byte, takes effect at the one rising edge that samples the strobe. The new lock state, index or output value is therefore visible one cycle after the stimulus. A read result appears on `bus_rdata` after the same single edge. The bench drives each strobe on a falling edge for exactly one cycle and samples at the next falling edge, halfway between that edge and the following one. A stability check after idle cycles covers the hold behaviour of the read register.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
   localparam int BYTE_W = 8;
   localparam int BASE_W = 16;

   localparam logic [7:0] IX_DEVSEL = 8'h07;
   localparam logic [7:0] IX_IDENT  = 8'h20;
   localparam logic [7:0] IX_REVN   = 8'h21;
   localparam logic [7:0] IX_CTL_A  = 8'h22;
   localparam logic [7:0] IX_CTL_B  = 8'h23;
   localparam logic [7:0] IX_CTL_C  = 8'h24;
   localparam logic [7:0] IX_BANK0  = 8'h30;
   localparam logic [7:0] IX_ACT    = 8'h30;
   localparam logic [7:0] IX_BASE_H = 8'h60;
   localparam logic [7:0] IX_BASE_L = 8'h61;
   localparam logic [7:0] IX_IRQ_A  = 8'h70;
   localparam logic [7:0] IX_IRQ_B  = 8'h72;
   localparam logic [7:0] IX_MODE   = 8'hF0;

   typedef enum logic {CFG_LOCKED = 1'b0, CFG_OPEN = 1'b1} cfg_state_t;
endpackage

// File: rtl/kcp_unlock.sv
module kcp_unlock
   import kcp_pkg::*;
#(
   parameter logic [7:0] KEY_ON  = 8'h55,
   parameter logic [7:0] KEY_OFF = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       cfg_on,
   output logic [7:0] index
);
   cfg_state_t state_q;

   if (KEY_ON == KEY_OFF) begin : g_bad_keys
      $error("kcp_unlock: KEY_ON and KEY_OFF must differ");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CFG_LOCKED;
         index   <= '0;
      end else if (idx_wr) begin
         if (state_q == CFG_LOCKED) begin
            if (wdata == KEY_ON) state_q <= CFG_OPEN;
         end else if (wdata == KEY_OFF) begin
            state_q <= CFG_LOCKED;
         end else begin
            index <= wdata;
         end
      end
   end

   assign cfg_on = (state_q == CFG_OPEN);
endmodule

// File: rtl/kcp_global_regs.sv
module kcp_global_regs
   import kcp_pkg::*;
#(
   parameter logic [7:0] CHIP_ID = 8'h4D,
   parameter logic [7:0] REV     = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] index,
   input  logic [7:0] wdata,
   output logic [7:0] devsel,
   output logic [7:0] rdata
);
   logic [7:0] ctl_a_q, ctl_b_q, ctl_c_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         devsel  <= '0;
         ctl_a_q <= '0;
         ctl_b_q <= '0;
         ctl_c_q <= '0;
      end else if (wr_en) begin
         case (index)
            IX_DEVSEL: devsel  <= wdata;
            IX_CTL_A:  ctl_a_q <= wdata;
            IX_CTL_B:  ctl_b_q <= wdata;
            IX_CTL_C:  ctl_c_q <= wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (index)
         IX_DEVSEL: rdata = devsel;
         IX_IDENT:  rdata = CHIP_ID;
         IX_REVN:   rdata = REV;
         IX_CTL_A:  rdata = ctl_a_q;
         IX_CTL_B:  rdata = ctl_b_q;
         IX_CTL_C:  rdata = ctl_c_q;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/kcp_dev_bank.sv
module kcp_dev_bank
   import kcp_pkg::*;
#(
   parameter int IRQ_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [7:0]        index,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              en,
   output logic [BASE_W-1:0] base,
   output logic [IRQ_W-1:0]  irq_a,
   output logic [IRQ_W-1:0]  irq_b,
   output logic [7:0]        mode
);
   if (IRQ_W < 1 || IRQ_W > BYTE_W) begin : g_bad_irq_w
      $error("kcp_dev_bank: IRQ_W must be 1..8");
   end

   logic bank_wr;
   assign bank_wr = sel && wr_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         base  <= '0;
         irq_a <= '0;
         irq_b <= '0;
         mode  <= '0;
      end else if (bank_wr) begin
         case (index)
            IX_ACT:    en          <= wdata[0];
            IX_BASE_H: base[15:8]  <= wdata;
            IX_BASE_L: base[7:0]   <= wdata;
            IX_IRQ_A:  irq_a       <= wdata[IRQ_W-1:0];
            IX_IRQ_B:  irq_b       <= wdata[IRQ_W-1:0];
            IX_MODE:   mode        <= wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (index)
            IX_ACT:    rdata = {7'b0, en};
            IX_BASE_H: rdata = base[15:8];
            IX_BASE_L: rdata = base[7:0];
            IX_IRQ_A:  rdata = 8'(irq_a);
            IX_IRQ_B:  rdata = 8'(irq_b);
            IX_MODE:   rdata = mode;
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import kcp_pkg::*;
#(
   parameter int                 NUM_DEV = 4,
   parameter logic [NUM_DEV*8-1:0] DEV_IDS = {8'h07, 8'h05, 8'h04, 8'h00},
   parameter int                 IRQ_W   = 4,
   parameter logic [7:0]         CHIP_ID = 8'h4D,
   parameter logic [7:0]         REV     = 8'h01,
   parameter logic [7:0]         KEY_ON  = 8'h55,
   parameter logic [7:0]         KEY_OFF = 8'hAA
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic                      bus_addr,
   input  logic [7:0]                bus_wdata,
   output logic [7:0]                bus_rdata,
   output logic [NUM_DEV-1:0]        dev_en,
   output logic [NUM_DEV*BASE_W-1:0] dev_base,
   output logic [NUM_DEV*IRQ_W-1:0]  dev_irq_a,
   output logic [NUM_DEV*IRQ_W-1:0]  dev_irq_b,
   output logic [NUM_DEV*8-1:0]      dev_mode
);
   localparam logic ADDR_INDEX = 1'b0;
   localparam logic ADDR_DATA  = 1'b1;

   if (NUM_DEV < 1 || NUM_DEV > 16) begin : g_bad_num_dev
      $error("keyed_cfg_port: NUM_DEV must be 1..16");
   end
   for (genvar i = 0; i < NUM_DEV; i++) begin : g_dup_i
      for (genvar j = i + 1; j < NUM_DEV; j++) begin : g_dup_j
         if (DEV_IDS[i*8 +: 8] == DEV_IDS[j*8 +: 8]) begin : g_dup
            $error("keyed_cfg_port: duplicate device number");
         end
      end
   end

   logic       cfg_on;
   logic [7:0] index;
   logic [7:0] devsel;
   logic [7:0] glb_rdata;
   logic [7:0] bank_rdata;
   logic [7:0] reg_rdata;
   logic       idx_wr, dat_wr, in_bank;
   logic [7:0] bank_rd [NUM_DEV];

   assign idx_wr  = bus_wr && (bus_addr == ADDR_INDEX);
   assign dat_wr  = bus_wr && (bus_addr == ADDR_DATA) && cfg_on;
   assign in_bank = (index >= IX_BANK0);

   kcp_unlock #(.KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_wr (idx_wr),
      .wdata  (bus_wdata),
      .cfg_on (cfg_on),
      .index  (index)
   );

   kcp_global_regs #(.CHIP_ID(CHIP_ID), .REV(REV)) u_glb (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (dat_wr && !in_bank),
      .index  (index),
      .wdata  (bus_wdata),
      .devsel (devsel),
      .rdata  (glb_rdata)
   );

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      logic hit;
      assign hit = (devsel == DEV_IDS[d*8 +: 8]);
      kcp_dev_bank #(.IRQ_W(IRQ_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .sel   (hit),
         .wr_en (dat_wr && in_bank),
         .index (index),
         .wdata (bus_wdata),
         .rdata (bank_rd[d]),
         .en    (dev_en[d]),
         .base  (dev_base[d*BASE_W +: BASE_W]),
         .irq_a (dev_irq_a[d*IRQ_W +: IRQ_W]),
         .irq_b (dev_irq_b[d*IRQ_W +: IRQ_W]),
         .mode  (dev_mode[d*8 +: 8])
      );
   end

   always_comb begin
      bank_rdata = '0;
      for (int d = 0; d < NUM_DEV; d++) bank_rdata = bank_rdata | bank_rd[d];
   end

   assign reg_rdata = in_bank ? bank_rdata : glb_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         if (!cfg_on)                     bus_rdata <= 8'hFF;
         else if (bus_addr == ADDR_INDEX) bus_rdata <= index;
         else                             bus_rdata <= reg_rdata;
      end
   end
endmodule

// File: rtl/kcp_checker.sv
module kcp_checker #(
   parameter int NUM_DEV = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic               bus_addr,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic [NUM_DEV-1:0] dev_en,
   input logic               cfg_on
);
   p_locked_read_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_on && bus_rd) |=> (bus_rdata == 8'hFF));

   p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_on && bus_wr && !bus_addr && bus_wdata == 8'h55) |=> cfg_on);

   p_key_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_on && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_on);

   p_stays_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_on && !(bus_wr && !bus_addr && bus_wdata == 8'h55)) |=> !cfg_on);

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   p_locked_en_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_on |=> $stable(dev_en));
endmodule

bind keyed_cfg_port kcp_checker #(.NUM_DEV(NUM_DEV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .dev_en    (dev_en),
   .cfg_on    (cfg_on)
);

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [3:0]  dev_en;
   logic [63:0] dev_base;
   logic [15:0] dev_irq_a, dev_irq_b;
   logic [31:0] dev_mode;
   int total = 0, bad = 0;
   logic [7:0] got;

   always #5 clk = ~clk;

   keyed_cfg_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_en(dev_en), .dev_base(dev_base), .dev_irq_a(dev_irq_a),
      .dev_irq_b(dev_irq_b), .dev_mode(dev_mode)
   );

   // {req, kind (1 = write, 2 = read and compare), index, data or expected}
   localparam int NV = 37;
   localparam logic [31:0] VEC [NV] = '{
      {8'd5,  8'd1, 8'h07, 8'h04},  // R5 select slot 1
      {8'd6,  8'd1, 8'h30, 8'hFF},  // R6
      {8'd6,  8'd2, 8'h30, 8'h01},  // R6 only bit 0 kept
      {8'd6,  8'd1, 8'h60, 8'h12},
      {8'd6,  8'd1, 8'h61, 8'h34},
      {8'd6,  8'd2, 8'h60, 8'h12},
      {8'd6,  8'd2, 8'h61, 8'h34},
      {8'd6,  8'd1, 8'h70, 8'hAB},
      {8'd6,  8'd2, 8'h70, 8'h0B},  // R6 4-bit field
      {8'd6,  8'd1, 8'h72, 8'h35},
      {8'd6,  8'd2, 8'h72, 8'h05},
      {8'd6,  8'd1, 8'hF0, 8'hC3},
      {8'd6,  8'd2, 8'hF0, 8'hC3},
      {8'd5,  8'd1, 8'h07, 8'h07},  // R5 select slot 3
      {8'd5,  8'd2, 8'h30, 8'h00},  // R5 separate bank
      {8'd5,  8'd1, 8'h30, 8'h01},
      {8'd5,  8'd2, 8'h30, 8'h01},
      {8'd7,  8'd1, 8'h07, 8'h02},  // R7 unmatched number
      {8'd7,  8'd1, 8'h60, 8'hEE},
      {8'd7,  8'd2, 8'h60, 8'h00},
      {8'd7,  8'd2, 8'h30, 8'h00},
      {8'd4,  8'd2, 8'h20, 8'h4D},  // R4
      {8'd4,  8'd1, 8'h20, 8'h11},
      {8'd4,  8'd2, 8'h20, 8'h4D},
      {8'd4,  8'd2, 8'h21, 8'h01},
      {8'd12, 8'd1, 8'h22, 8'h5A},  // R12
      {8'd12, 8'd2, 8'h22, 8'h5A},
      {8'd12, 8'd1, 8'h23, 8'hA5},
      {8'd12, 8'd2, 8'h23, 8'hA5},
      {8'd12, 8'd1, 8'h24, 8'h3C},
      {8'd12, 8'd2, 8'h24, 8'h3C},
      {8'd8,  8'd1, 8'h25, 8'h77},  // R8
      {8'd8,  8'd2, 8'h25, 8'h00},
      {8'd8,  8'd1, 8'h07, 8'h04},
      {8'd8,  8'd1, 8'h31, 8'h66},
      {8'd8,  8'd2, 8'h31, 8'h00},
      {8'd5,  8'd2, 8'h07, 8'h04}
   };

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive one strobe for one cycle from a falling edge; return at next falling edge
   task automatic bus_op(input logic wr, input logic rd, input logic a, input logic [7:0] d);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
      bus_op(1'b1, 1'b0, 1'b0, ix);
      bus_op(1'b1, 1'b0, 1'b1, d);
   endtask

   task automatic rd_reg(input logic [7:0] ix, output logic [7:0] v);
      bus_op(1'b1, 1'b0, 1'b0, ix);
      bus_op(1'b0, 1'b1, 1'b1, 8'h00);
      v = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk(1, {28'd0, dev_en}, 0, "dev_en after reset");
      chk(1, dev_base[31:0], 0, "base after reset");
      chk(1, {24'd0, bus_rdata}, 0, "rdata after reset");
      bus_op(1'b0, 1'b1, 1'b1, 8'h00);
      chk(3, {24'd0, bus_rdata}, 32'hFF, "locked data read");  // R3
      wr_reg(8'h07, 8'h04);  // locked: ignored (R3)
      bus_op(1'b1, 1'b0, 1'b0, 8'h55);  // R2 unlock
      rd_reg(8'h07, got);
      chk(3, {24'd0, got}, 0, "selector untouched while locked");

      for (int k = 0; k < NV; k++) begin
         if (VEC[k][23:16] == 8'd1) wr_reg(VEC[k][15:8], VEC[k][7:0]);
         else begin
            rd_reg(VEC[k][15:8], got);
            chk(int'(VEC[k][31:24]), {24'd0, got}, {24'd0, VEC[k][7:0]}, $sformatf("vector %0d", k));
         end
      end

      // R9 outputs per slot
      chk(9, {28'd0, dev_en}, 32'b1010, "dev_en");
      chk(9, {16'd0, dev_base[31:16]}, 32'h1234, "slot1 base");
      chk(9, {16'd0, dev_irq_a[7:4], dev_irq_b[7:4], dev_mode[15:8]}, 32'h0000_B5C3, "slot1 irq/mode");
      chk(9, {dev_base[63:48], dev_base[15:0]}, 0, "other bases");

      // R10 index persists, index port readback
      bus_op(1'b1, 1'b0, 1'b0, 8'h22);
      bus_op(1'b0, 1'b1, 1'b1, 8'h00);
      chk(10, {24'd0, bus_rdata}, 32'h5A, "repeat read 1");
      bus_op(1'b0, 1'b1, 1'b1, 8'h00);
      chk(10, {24'd0, bus_rdata}, 32'h5A, "repeat read 2");
      bus_op(1'b0, 1'b1, 1'b0, 8'h00);
      chk(10, {24'd0, bus_rdata}, 32'h22, "index port read");

      // R2 lock, R3 locked behaviour
      bus_op(1'b1, 1'b0, 1'b0, 8'hAA);
      bus_op(1'b0, 1'b1, 1'b0, 8'h00);
      chk(3, {24'd0, bus_rdata}, 32'hFF, "locked index read");
      bus_op(1'b1, 1'b0, 1'b0, 8'h07);
      bus_op(1'b1, 1'b0, 1'b1, 8'h99);
      chk(3, {28'd0, dev_en}, 32'b1010, "dev_en after locked write");
      bus_op(1'b1, 1'b0, 1'b0, 8'h55);
      bus_op(1'b0, 1'b1, 1'b1, 8'h00);
      chk(2, {24'd0, bus_rdata}, 32'h5A, "index kept over lock/unlock");
      bus_op(1'b0, 1'b1, 1'b0, 8'h00);
      chk(2, {24'd0, bus_rdata}, 32'h22, "index after relock");

      // R11 hold
      repeat (3) @(negedge clk);
      chk(11, {24'd0, bus_rdata}, 32'h22, "rdata holds while idle");

      // R1 reset mid-run
      do_reset();
      chk(1, {28'd0, dev_en}, 0, "dev_en after second reset");
      chk(1, {dev_irq_a, dev_irq_b}, 0, "irq after reset");
      chk(1, dev_mode, 0, "mode after reset");
      bus_op(1'b0, 1'b1, 1'b1, 8'h00);
      chk(1, {24'd0, bus_rdata}, 32'hFF, "locked after reset");
      bus_op(1'b1, 1'b0, 1'b0, 8'h55);
      bus_op(1'b0, 1'b1, 1'b0, 8'h00);
      chk(1, {24'd0, bus_rdata}, 0, "index cleared");
      rd_reg(8'h07, got);
      chk(1, {24'd0, got}, 0, "selector cleared");
      rd_reg(8'h22, got);
      chk(1, {24'd0, got}, 0, "control byte cleared");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule